// File: doc/BRIEF.md
# Forwarded-Clock Three-Lane 7:1 Serializer

This block takes a 21-bit word on every rising edge of a parallel clock and sends it out over three serial data lanes, seven bits per lane in each parallel period. A fourth lane carries a forwarded clock with the same period as the parallel clock, so a receiver can recover the bit slots from its rising edge. The bit clock runs at seven times the parallel clock and is supplied already phase-aligned to it; no frequency synthesis is modelled. Each slot lasts one bit-clock period, which is one seventh of a parallel period.

An active-low power-down input switches every lane to the high-impedance state, which is modelled here as a per-lane output enable. After reset or after power-down is released, the lanes are driven but kept quiet for a lock interval of `LOCK_CYCLES` parallel periods. Only after that interval does serial traffic start, and it always starts on a period boundary.

Top module: `lane_serializer_tx`

## Requirements
- R1: While `rst_n` is low, every lane enable and every lane output is low.
- R2: In a running period, data lane k carries input bit 7k+s in bit slot s. Slot 0 begins at the rising parallel edge and slots follow in increasing order, one bit-clock period each.
- R3: The word sampled at parallel rising edge n is transmitted in the period that starts at edge n+1.
- R4: In a running period the forwarded clock lane is high in slots 0 to 3 and low in slots 4 to 6, so its rising edge marks slot 0. Outside such periods it is low.
- R5: When reset is released just after a parallel rising edge, the lanes stay idle for `LOCK_CYCLES` full periods. The first running period starts at the (`LOCK_CYCLES`+1)-th parallel rising edge after the release.
- R6: When `pd_n` rises just after a parallel rising edge, the same lock interval applies, counted from that release.
- R7: From the first bit-clock rising edge after `pd_n` falls, all lane enables are low and all lane outputs are low. This holds for as long as `pd_n` stays low.
- R8: While idle (powered but not yet running), all enables are high and every data lane and the clock lane are driven low.
- R9: A power-down that falls inside a lock interval restarts the count. Running begins only `LOCK_CYCLES`+1 edges after the final release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_par | input | 1 | Parallel word clock; the word is sampled on its rising edge |
| clk_bit | input | 1 | Bit clock, seven times `clk_par`, rising edges aligned with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| data_in | input | 21 | Parallel input word |
| lane_dat | output | 3 | Serial data lanes |
| lane_oe | output | 3 | Per-lane output enable (low = high impedance) |
| fclk_lane | output | 1 | Forwarded clock lane |
| fclk_oe | output | 1 | Output enable of the forwarded clock lane |

## Verification
A slot counter that drifts from the parallel clock shows up within one period in two ways. The forwarded clock loses its four-high, three-low shape, and the words recovered from the lanes come out rotated. A shift register loaded from the wrong word breaks the one-period latency, and the scoreboard compares every running period against the word sampled one edge earlier, so this fails at the next period. A lock counter that is not cleared by power-down, or that is off by one, moves the first toggling period by whole periods. It is caught by checking, period by period, which periods are off, idle or running after each release.

// File: rtl/lane_serializer_tx.sv
`timescale 1ns/1ps
module lane_serializer_tx #(
  parameter int LANES       = 3,
  parameter int SLOTS       = 7,
  parameter int LOCK_CYCLES = 4
) (
  input  logic                   clk_par,
  input  logic                   clk_bit,
  input  logic                   rst_n,
  input  logic                   pd_n,
  input  logic [LANES*SLOTS-1:0] data_in,
  output logic [LANES-1:0]       lane_dat,
  output logic [LANES-1:0]       lane_oe,
  output logic                   fclk_lane,
  output logic                   fclk_oe
);
  localparam int WIDTH = LANES * SLOTS;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW    = $clog2(LOCK_CYCLES + 1) + 1;
  localparam int HI    = (SLOTS + 1) / 2;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam logic [CW-1:0] LOCK = CW'(LOCK_CYCLES);

  logic [WIDTH-1:0] word_q;
  logic             par_tog;

  always_ff @(posedge clk_par or negedge rst_n)
    if (!rst_n) begin
      word_q  <= '0;
      par_tog <= 1'b0;
    end else begin
      word_q  <= data_in;
      par_tog <= ~par_tog;
    end

  logic          tog_s, pd_q, run;
  logic [SW-1:0] slot;
  logic [CW-1:0] lock_cnt;

  wire resync = tog_s ^ par_tog;
  wire wrap   = (slot == LAST) && !resync;
  wire live   = pd_q & run;

  always_ff @(posedge clk_bit or negedge rst_n)
    if (!rst_n) begin
      tog_s    <= 1'b0;
      pd_q     <= 1'b0;
      slot     <= '0;
      lock_cnt <= '0;
      run      <= 1'b0;
    end else begin
      tog_s <= par_tog;
      pd_q  <= pd_n;
      if (resync)      slot <= SW'(1);
      else if (wrap)   slot <= '0;
      else             slot <= slot + SW'(1);
      if (!pd_q) begin
        lock_cnt <= '0;
        run      <= 1'b0;
      end else if (wrap) begin
        if (lock_cnt == LOCK) run <= 1'b1;
        else                  lock_cnt <= lock_cnt + CW'(1);
      end
    end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLOTS-1:0] sh;
    always_ff @(posedge clk_bit or negedge rst_n)
      if (!rst_n)    sh <= '0;
      else if (wrap) sh <= word_q[k*SLOTS +: SLOTS];
      else           sh <= sh >> 1;
    assign lane_dat[k] = live & sh[0];
    assign lane_oe[k]  = pd_q;
  end

  assign fclk_lane = live & (slot < SW'(HI));
  assign fclk_oe   = pd_q;
endmodule

// File: rtl/lane_serializer_tx_chk.sv
`timescale 1ns/1ps
module lane_serializer_tx_chk #(
  parameter int LANES       = 3,
  parameter int SLOTS       = 7,
  parameter int LOCK_CYCLES = 4
) (
  input logic clk_bit,
  input logic rst_n,
  input logic pd_n,
  input logic pd_q,
  input logic run,
  input logic [((SLOTS > 1) ? $clog2(SLOTS) : 1)-1:0] slot,
  input logic [$clog2(LOCK_CYCLES + 1):0] lock_cnt,
  input logic [LANES-1:0] lane_dat,
  input logic [LANES-1:0] lane_oe,
  input logic fclk_lane,
  input logic fclk_oe
);
  localparam int CW = $clog2(LOCK_CYCLES + 1) + 1;

  // R1
  rst_off_chk: assert property (@(posedge clk_bit)
    !rst_n |-> (lane_oe == '0 && !fclk_oe && lane_dat == '0 && !fclk_lane));

  // R7
  pd_off_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pd_n |=> (lane_oe == '0 && !fclk_oe && lane_dat == '0 && !fclk_lane));

  // R4
  fclk_rise_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(fclk_lane) |-> (slot == '0 && fclk_oe));

  // R5
  run_start_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(run) |-> (slot == '0 && lock_cnt == CW'(LOCK_CYCLES)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (pd_q && !run) |-> (lane_oe == '1 && lane_dat == '0 && !fclk_lane));

  // R9
  restart_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $fell(pd_q) |=> (lock_cnt == '0 && !run));
endmodule

bind lane_serializer_tx lane_serializer_tx_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .LOCK_CYCLES(LOCK_CYCLES)
) chk_i (
  .clk_bit(clk_bit), .rst_n(rst_n), .pd_n(pd_n), .pd_q(pd_q), .run(run),
  .slot(slot), .lock_cnt(lock_cnt), .lane_dat(lane_dat), .lane_oe(lane_oe),
  .fclk_lane(fclk_lane), .fclk_oe(fclk_oe)
);

// File: tb/lane_serializer_tx_tb_top.sv
`timescale 1ns/1ps
module lane_serializer_tx_tb_top;
  localparam int LANES = 3, SLOTS = 7, LOCK = 4, W = LANES * SLOTS;
  localparam int C_OFF = 0, C_IDLE = 1, C_RUN = 2, C_OTHER = 3;

  logic clk_par = 0, clk_bit = 0, rst_n = 0, pd_n = 1;
  logic [W-1:0] data_in = '0;
  logic [LANES-1:0] lane_dat, lane_oe;
  logic fclk_lane, fclk_oe;

  lane_serializer_tx #(.LANES(LANES), .SLOTS(SLOTS), .LOCK_CYCLES(LOCK)) dut_i (
    .clk_par(clk_par), .clk_bit(clk_bit), .rst_n(rst_n), .pd_n(pd_n),
    .data_in(data_in), .lane_dat(lane_dat), .lane_oe(lane_oe),
    .fclk_lane(fclk_lane), .fclk_oe(fclk_oe));

  initial forever #2.5 clk_bit = ~clk_bit;
  initial begin
    #2.5;
    forever begin clk_par = 1; #17.5; clk_par = 0; #17.5; end
  end

  int errs = 0, checks = 0, mode = 0, cur_per = -1;
  int cls [0:1023];
  logic [W-1:0] exp_q [$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one word per parallel period, expected copy into the queue
  initial begin
    logic [W-1:0] w, lfsr;
    int n;
    n = 0; lfsr = 21'h1A5F3;
    forever begin
      @(posedge clk_par); #1;
      case (mode)
        0: w = W'(n * 3 + 1);
        1: w = W'(1) << (n % W);
        2: w = (n % 3 == 0) ? '1 : ((n % 3 == 1) ? '0 : 21'h155555);
        default: begin lfsr = {lfsr[W-2:0], lfsr[W-1] ^ lfsr[W-3]}; w = lfsr; end
      endcase
      data_in = w;
      exp_q.push_back(w);
      n++;
    end
  end

  // monitor: rebuild each period from mid-slot samples, compare running ones (R2, R3)
  initial begin
    logic [W-1:0] rx, w;
    logic [SLOTS-1:0] cp;
    bit oa, oo, dor;
    int c;
    forever begin
      @(posedge clk_par);
      cur_per++;
      rx = '0; cp = '0; oa = 1; oo = 0; dor = 0;
      for (int s = 0; s < SLOTS; s++) begin
        @(negedge clk_bit);
        for (int k = 0; k < LANES; k++) rx[k*SLOTS+s] = lane_dat[k];
        cp[s] = fclk_lane;
        oa &= (&lane_oe) & fclk_oe;
        oo |= (|lane_oe) | fclk_oe;
        dor |= |lane_dat;
      end
      if (!oo && !dor && cp == '0)      c = C_OFF;
      else if (oa && !dor && cp == '0)  c = C_IDLE;
      else if (oa && cp == 7'h0F)       c = C_RUN;
      else                              c = C_OTHER;
      if (cur_per < 1024) cls[cur_per] = c;
      if (oa) chk(cp == '0 || cp == 7'h0F, "R4", "clock lane shape", 32'(cp), 32'h0F);
      if (exp_q.size() >= 3) begin
        w = exp_q.pop_front();
        if (c == C_RUN) chk(rx == w, "R2/R3", "lane word", 32'(rx), 32'(w));
      end
    end
  end

  task automatic lock_check(input int rel, input string req);
    for (int p = rel + 1; p <= rel + LOCK; p++)
      chk(cls[p] == C_IDLE, req, "idle during lock", 32'(cls[p]), 32'(C_IDLE));
    chk(cls[rel+LOCK+1] == C_RUN, req, "first running period", 32'(cls[rel+LOCK+1]), 32'(C_RUN));
  endtask

  initial begin
    int rel, p;
    repeat (2) @(posedge clk_par);
    @(negedge clk_bit);
    // R1
    chk(lane_oe == '0 && !fclk_oe && lane_dat == '0 && !fclk_lane, "R1", "reset outputs",
        {26'd0, fclk_oe, fclk_lane, lane_oe[1:0], lane_dat[1:0]}, 32'd0);
    @(posedge clk_par); #1; rel = cur_per; rst_n = 1;
    repeat (LOCK + 4) @(posedge clk_par);
    lock_check(rel, "R5");
    // R8: idle periods are driven low with enables high
    chk(cls[rel+1] == C_IDLE, "R8", "idle drive", 32'(cls[rel+1]), 32'(C_IDLE));
    repeat (10) @(posedge clk_par);
    mode = 1; repeat (24) @(posedge clk_par);
    mode = 2; repeat (12) @(posedge clk_par);
    mode = 3; repeat (20) @(posedge clk_par);

    // R7: power-down while running
    #1; pd_n = 0;
    @(posedge clk_bit); @(negedge clk_bit);
    chk(lane_oe == '0 && !fclk_oe && lane_dat == '0 && !fclk_lane, "R7", "outputs off",
        {26'd0, fclk_oe, fclk_lane, lane_oe[1:0], lane_dat[1:0]}, 32'd0);
    @(posedge clk_par); #1; p = cur_per;
    repeat (2) @(posedge clk_par);
    chk(cls[p] == C_OFF, "R7", "period tri-stated", 32'(cls[p]), 32'(C_OFF));
    #1; rel = cur_per; pd_n = 1;
    repeat (LOCK + 4) @(posedge clk_par);
    lock_check(rel, "R6");
    repeat (6) @(posedge clk_par);

    // R9: power-down inside the lock interval restarts it
    #1; pd_n = 0;
    @(posedge clk_par); #1; pd_n = 1;
    repeat (2) @(posedge clk_par);
    #1; pd_n = 0;
    @(posedge clk_par); #1; rel = cur_per; pd_n = 1;
    repeat (LOCK + 4) @(posedge clk_par);
    lock_check(rel, "R9");
    mode = 0; repeat (10) @(posedge clk_par);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #60000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule